// File: doc/BRIEF.md
# ECC Fault Log Register Bank

This block is a small register bank that sits beside two ECC-protected memories, a flash region and a RAM region. It records memory faults reported by the ECC logic of each region. For every region it receives a one-cycle event that flags either a correctable or a non-correctable fault. Along with that flag come the faulting address, the number of the bus master that made the access, the access attributes and the data word.

Software reaches the bank through a simple bus-slave port. A request carries a write flag, a byte address, an access size and write data. The block answers every request exactly one cycle later with a response strobe, an error flag and read data. The bus checks each access strictly: unknown addresses and writes of the wrong width are refused, and writes to the capture registers are silently dropped.

An 8-bit configuration register enables reporting for each region and each fault class. A write-one-to-clear status register latches the enabled faults. Each region has its own set of capture registers. A single interrupt line is raised while any enabled status bit is set. Non-correctable faults are also passed straight back to the memory path as an access-error signal, so that the faulting transfer ends in error whatever the enables are.

Top module: `ecc_fault_log`

## Requirements
- R1: After reset the configuration, status and all capture registers read as zero, `irq` is low and `rsp_valid` is low.
- R2: Every cycle with `bus_req` high produces `rsp_valid` high in the next cycle. `rsp_rdata` holds the register's value from before that request (zero-extended) for an accepted read, and zero for a write or a refused access. Register map (byte addresses): 0x00 configuration (8-bit), 0x01 status (8-bit), RAM capture at 0x10 address (32-bit), 0x14 data (32-bit), 0x18 master (8-bit), 0x19 attributes (8-bit), flash capture at 0x20/0x24/0x28/0x29 with the same layout.
- R3: A read or write to any address outside that map returns `rsp_err` high and changes no register.
- R4: A write whose `bus_size` (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = none) differs from the width of the target register returns `rsp_err` high and leaves every register unchanged. Reads of any size are accepted.
- R5: A correctly sized write to any capture register returns `rsp_err` low and changes nothing.
- R6: Configuration and status share one bit layout: bit 0 RAM correctable, bit 1 RAM non-correctable, bit 2 flash correctable, bit 3 flash non-correctable. Bits 7:4 of both always read zero.
- R7: `ram_acc_err` and `fl_acc_err` are high in the same cycle as that region's non-correctable event, whatever the enables.
- R8: A fault event whose enable bit is set makes the matching status bit read one from the next cycle on. A fault whose enable is clear sets no status bit and loads no capture register.
- R9: An enabled fault in a region loads that region's address, master, attributes and data captures. These hold until the next enabled fault in the same region, and a fault in the other region does not touch them.
- R10: Writing one to a status bit clears it and writing zero leaves it alone. If an enabled fault and a clearing write reach the same bit in the same cycle, the bit stays set.
- R11: `irq` is high exactly when some status bit is set and its configuration bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, one per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Byte address of the register |
| bus_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| bus_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Access refused |
| rsp_rdata | output | 32 | Read data |
| ram_cor | input | 1 | RAM correctable fault event |
| ram_ncor | input | 1 | RAM non-correctable fault event |
| ram_addr | input | ADDR_W | RAM faulting address |
| ram_mst | input | MST_W | RAM faulting master number |
| ram_attr | input | ATTR_W | RAM access attributes |
| ram_data | input | DATA_W | RAM faulting data |
| fl_cor | input | 1 | Flash correctable fault event |
| fl_ncor | input | 1 | Flash non-correctable fault event |
| fl_addr | input | ADDR_W | Flash faulting address |
| fl_mst | input | MST_W | Flash faulting master number |
| fl_attr | input | ATTR_W | Flash access attributes |
| fl_data | input | DATA_W | Flash faulting data |
| ram_acc_err | output | 1 | Ends the current RAM access in error |
| fl_acc_err | output | 1 | Ends the current flash access in error |
| irq | output | 1 | Error interrupt request |

## Verification
The hardest case to reach is a cycle in which a fault event and a status clear by software land on the same bit. Close behind it come two cycles that software alone never produces: faults in both regions at once, and a fault while a write to the configuration register is changing the enables. The stimulus drives the bus and both event inputs at the same time on every random cycle. It picks addresses mostly from the register map and aims status writes at set bits, so these overlaps occur many times. A directed cycle places a clear and a fault on status bit 0 together.

// File: rtl/ecc_fault_log.sv
module ecc_fault_log #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int MST_W  = 4,
  parameter int ATTR_W = 8,
  parameter int BUS_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  input  logic              ram_cor,
  input  logic              ram_ncor,
  input  logic [ADDR_W-1:0] ram_addr,
  input  logic [MST_W-1:0]  ram_mst,
  input  logic [ATTR_W-1:0] ram_attr,
  input  logic [DATA_W-1:0] ram_data,
  input  logic              fl_cor,
  input  logic              fl_ncor,
  input  logic [ADDR_W-1:0] fl_addr,
  input  logic [MST_W-1:0]  fl_mst,
  input  logic [ATTR_W-1:0] fl_attr,
  input  logic [DATA_W-1:0] fl_data,
  output logic              ram_acc_err,
  output logic              fl_acc_err,
  output logic              irq
);
  localparam int NREG   = 2;
  localparam int NBITS  = 2 * NREG;
  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_W = 2'd2;
  localparam logic [BUS_AW-1:0] OFF_CFG  = BUS_AW'(0);
  localparam logic [BUS_AW-1:0] OFF_STAT = BUS_AW'(1);
  localparam int BASE_STEP = 16;

  logic [NBITS-1:0] cfg_q, stat_q;
  logic [NREG-1:0][ADDR_W-1:0] cap_addr;
  logic [NREG-1:0][DATA_W-1:0] cap_data;
  logic [NREG-1:0][MST_W-1:0]  cap_mst;
  logic [NREG-1:0][ATTR_W-1:0] cap_attr;

  logic [NREG-1:0]             ev_cor, ev_ncor;
  logic [NREG-1:0][ADDR_W-1:0] ev_addr;
  logic [NREG-1:0][DATA_W-1:0] ev_data;
  logic [NREG-1:0][MST_W-1:0]  ev_mst;
  logic [NREG-1:0][ATTR_W-1:0] ev_attr;

  assign ev_cor  = {fl_cor, ram_cor};
  assign ev_ncor = {fl_ncor, ram_ncor};
  assign ev_addr = {fl_addr, ram_addr};
  assign ev_data = {fl_data, ram_data};
  assign ev_mst  = {fl_mst, ram_mst};
  assign ev_attr = {fl_attr, ram_attr};

  assign ram_acc_err = ram_ncor;
  assign fl_acc_err  = fl_ncor;

  logic        hit;
  logic [1:0]  need_sz;
  logic [31:0] rd_val;

  always_comb begin
    hit     = 1'b0;
    need_sz = SZ_B;
    rd_val  = '0;
    if (bus_addr == OFF_CFG) begin
      hit    = 1'b1;
      rd_val = 32'(cfg_q);
    end else if (bus_addr == OFF_STAT) begin
      hit    = 1'b1;
      rd_val = 32'(stat_q);
    end
    for (int r = 0; r < NREG; r++) begin
      if (bus_addr == BUS_AW'(BASE_STEP * (r + 1))) begin
        hit = 1'b1; need_sz = SZ_W; rd_val = 32'(cap_addr[r]);
      end
      if (bus_addr == BUS_AW'(BASE_STEP * (r + 1) + 4)) begin
        hit = 1'b1; need_sz = SZ_W; rd_val = 32'(cap_data[r]);
      end
      if (bus_addr == BUS_AW'(BASE_STEP * (r + 1) + 8)) begin
        hit = 1'b1; need_sz = SZ_B; rd_val = 32'(cap_mst[r]);
      end
      if (bus_addr == BUS_AW'(BASE_STEP * (r + 1) + 9)) begin
        hit = 1'b1; need_sz = SZ_B; rd_val = 32'(cap_attr[r]);
      end
    end
  end

  wire acc_err = bus_req && (!hit || (bus_wr && bus_size != need_sz));
  wire wr_ok   = bus_req && bus_wr && !acc_err;
  wire [NBITS-1:0] clr = (wr_ok && bus_addr == OFF_STAT) ? bus_wdata[NBITS-1:0] : '0;

  logic [NBITS-1:0] set;
  always_comb
    for (int r = 0; r < NREG; r++) begin
      set[2*r]   = ev_cor[r]  & cfg_q[2*r];
      set[2*r+1] = ev_ncor[r] & cfg_q[2*r+1];
    end

  assign irq = |(stat_q & cfg_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_q  <= '0;
      stat_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | set;
      if (wr_ok && bus_addr == OFF_CFG) cfg_q <= bus_wdata[NBITS-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= bus_req;
      rsp_err   <= acc_err;
      rsp_rdata <= (bus_req && !bus_wr && hit) ? rd_val : '0;
    end

  for (genvar r = 0; r < NREG; r++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cap_addr[r] <= '0;
        cap_data[r] <= '0;
        cap_mst[r]  <= '0;
        cap_attr[r] <= '0;
      end else if (set[2*r] || set[2*r+1]) begin
        cap_addr[r] <= ev_addr[r];
        cap_data[r] <= ev_data[r];
        cap_mst[r]  <= ev_mst[r];
        cap_attr[r] <= ev_attr[r];
      end
  end
endmodule

// File: rtl/ecc_fault_log_chk.sv
module ecc_fault_log_chk #(
  parameter int ADDR_W = 32,
  parameter int BUS_AW = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_wr,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              ram_cor,
  input logic              ram_ncor,
  input logic              fl_cor,
  input logic              fl_ncor,
  input logic [3:0]        cfg_q,
  input logic [3:0]        stat_q,
  input logic [1:0][ADDR_W-1:0] cap_addr,
  input logic              irq
);
  function automatic bit mapped(input logic [BUS_AW-1:0] a);
    int v;
    v = int'(a);
    return v == 0 || v == 1 || v == 16 || v == 20 || v == 24 || v == 25 ||
           v == 32 || v == 36 || v == 40 || v == 41;
  endfunction

  wire ram_rep = (ram_cor && cfg_q[0]) || (ram_ncor && cfg_q[1]);
  wire fl_rep  = (fl_cor && cfg_q[2]) || (fl_ncor && cfg_q[3]);

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> rsp_valid);
  assert_reserved_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !mapped(bus_addr)) |=> rsp_err);
  assert_cfg_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && bus_addr == '0 && bus_size != 2'd0) |=> (rsp_err && $stable(cfg_q)));
  assert_ram_ncor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_ncor && cfg_q[1]) |=> stat_q[1]);
  assert_fl_ncor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_ncor && cfg_q[3]) |=> stat_q[3]);
  assert_ram_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_rep |=> $stable(cap_addr[0]));
  assert_fl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_rep |=> $stable(cap_addr[1]));
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_cor && cfg_q[0]) |=> stat_q[0]);
  assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ram_rep || fl_rep || (bus_req && bus_wr)));
endmodule

bind ecc_fault_log ecc_fault_log_chk #(.ADDR_W(ADDR_W), .BUS_AW(BUS_AW)) u_chk (.*);

// File: tb/ecc_fault_log_test.sv
module ecc_fault_log_test;
  localparam int PERIOD = 10;
  localparam int SEED   = 32'h5EED_0A17;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 0, bus_wr = 0;
  logic [5:0] bus_addr = 0;
  logic [1:0] bus_size = 0;
  logic [31:0] bus_wdata = 0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic ram_cor = 0, ram_ncor = 0, fl_cor = 0, fl_ncor = 0;
  logic [31:0] ram_addr = 0, ram_data = 0, fl_addr = 0, fl_data = 0;
  logic [3:0] ram_mst = 0, fl_mst = 0;
  logic [7:0] ram_attr = 0, fl_attr = 0;
  logic ram_acc_err, fl_acc_err, irq;

  ecc_fault_log uut (.*);

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [3:0] mcfg = 0, mstat = 0;
  logic [31:0] m_addr [2], m_data [2];
  logic [3:0]  m_mst [2];
  logic [7:0]  m_attr [2];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit mvalid(input logic [5:0] a);
    return a == 0 || a == 1 || a == 16 || a == 20 || a == 24 || a == 25 ||
           a == 32 || a == 36 || a == 40 || a == 41;
  endfunction

  function automatic logic [1:0] msz(input logic [5:0] a);
    return (a == 16 || a == 20 || a == 32 || a == 36) ? 2'd2 : 2'd0;
  endfunction

  function automatic logic [31:0] mrd(input logic [5:0] a);
    case (a)
      0: return 32'(mcfg);
      1: return 32'(mstat);
      16: return m_addr[0];
      20: return m_data[0];
      24: return 32'(m_mst[0]);
      25: return 32'(m_attr[0]);
      32: return m_addr[1];
      36: return m_data[1];
      40: return 32'(m_mst[1]);
      41: return 32'(m_attr[1]);
      default: return 32'h0;
    endcase
  endfunction

  task automatic cyc(input bit rq, input bit wr, input logic [5:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, input bit rc, input bit rn, input bit fc, input bit fn,
                     input string tag);
    bit ee;
    logic [31:0] er;
    logic [3:0] set, clr;
    @(negedge clk);
    bus_req = rq; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
    ram_cor = rc; ram_ncor = rn; fl_cor = fc; fl_ncor = fn;
    ram_addr = $urandom; ram_data = $urandom; ram_mst = 4'($urandom); ram_attr = 8'($urandom);
    fl_addr = $urandom; fl_data = $urandom; fl_mst = 4'($urandom); fl_attr = 8'($urandom);
    #1;
    chk(ram_acc_err === rn, "R7", 32'(ram_acc_err), 32'(rn));
    chk(fl_acc_err === fn, "R7", 32'(fl_acc_err), 32'(fn));
    ee  = rq && (!mvalid(a) || (wr && sz != msz(a)));
    er  = (rq && !wr && mvalid(a)) ? mrd(a) : 32'h0;
    set = {fn & mcfg[3], fc & mcfg[2], rn & mcfg[1], rc & mcfg[0]};
    clr = (rq && wr && !ee && a == 1) ? wd[3:0] : 4'h0;
    if (set[1:0] != 0) begin
      m_addr[0] = ram_addr; m_data[0] = ram_data; m_mst[0] = ram_mst; m_attr[0] = ram_attr;
    end
    if (set[3:2] != 0) begin
      m_addr[1] = fl_addr; m_data[1] = fl_data; m_mst[1] = fl_mst; m_attr[1] = fl_attr;
    end
    mstat = (mstat & ~clr) | set;
    if (rq && wr && !ee && a == 0) mcfg = wd[3:0];
    @(posedge clk);
    #1;
    chk(rsp_valid === rq, {tag, " R2 valid"}, 32'(rsp_valid), 32'(rq));
    if (rq) begin
      chk(rsp_err === ee, {tag, " err"}, 32'(rsp_err), 32'(ee));
      chk(rsp_rdata === er, {tag, " R2 rdata"}, rsp_rdata, er);
    end
    chk(irq === |(mstat & mcfg), "R11 irq", 32'(irq), 32'(|(mstat & mcfg)));
    bus_req = 0; ram_cor = 0; ram_ncor = 0; fl_cor = 0; fl_ncor = 0;
  endtask

  task automatic rd(input logic [5:0] a, input string tag);
    cyc(1, 0, a, msz(a), 0, 0, 0, 0, 0, tag);
  endtask

  task automatic wr(input logic [5:0] a, input logic [1:0] sz, input logic [31:0] d, input string tag);
    cyc(1, 1, a, sz, d, 0, 0, 0, 0, tag);
  endtask

  localparam logic [5:0] MAP [10] = '{0, 1, 16, 20, 24, 25, 32, 36, 40, 41};

  initial begin
    void'($urandom(SEED));
    for (int r = 0; r < 2; r++) begin
      m_addr[r] = 0; m_data[r] = 0; m_mst[r] = 0; m_attr[r] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    chk(rsp_valid === 1'b0, "R1 rsp_valid", 32'(rsp_valid), 0);
    chk(irq === 1'b0, "R1 irq", 32'(irq), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) rd(MAP[i], "R1 reset value");

    wr(0, 2'd2, 32'hFF, "R4 cfg wrong size");
    rd(0, "R4 cfg unchanged");
    wr(0, 2'd0, 32'hFF, "R6 cfg write");
    rd(0, "R6 cfg upper zero");
    wr(16, 2'd2, 32'hDEAD_BEEF, "R5 ro write");
    wr(24, 2'd0, 32'h55, "R5 ro byte write");
    wr(16, 2'd0, 32'h1, "R4 ro wrong size");
    rd(16, "R5 ro unchanged");
    rd(6'd3, "R3 reserved read");
    wr(6'd2, 2'd0, 32'hF, "R3 reserved write");
    rd(1, "R3 status unchanged");

    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, "R8 ram ncor");
    rd(1, "R8 status");
    rd(16, "R9 ram addr");
    rd(32, "R9 flash untouched");
    wr(0, 2'd0, 32'h0, "R8 disable");
    cyc(0, 0, 0, 0, 0, 1, 1, 1, 1, "R8 disabled events");
    rd(1, "R8 status after disabled");
    rd(20, "R8 no capture");
    rd(36, "R8 no capture flash");
    wr(0, 2'd0, 32'hF, "R10 enable");
    wr(1, 2'd0, 32'h2, "R10 clear bit1");
    rd(1, "R10 cleared");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, "R10 set bit0");
    cyc(1, 1, 1, 2'd0, 32'h1, 1, 0, 0, 0, "R10 set beats clear");
    rd(1, "R10 bit stays set");
    rd(0, "R6 cfg");

    for (int i = 0; i < 2500; i++) begin
      logic [5:0] a;
      logic [1:0] sz;
      logic [31:0] wd;
      int p;
      p = int'($urandom % 12);
      a = (p < 10) ? MAP[p] : 6'($urandom);
      sz = ($urandom % 4 != 0) ? msz(a) : 2'($urandom);
      wd = (a == 1) ? (($urandom % 2) ? 32'(mstat) : $urandom) : $urandom;
      cyc(($urandom % 10) < 7, $urandom % 2, a, sz, wd,
          ($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 5) == 0,
          "R3 R4 R8 R9 R10 random");
    end
    for (int i = 0; i < 10; i++) rd(MAP[i], "R9 final readback");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule